// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block runs a small general-purpose I/O port whose pins are also wanted by on-chip peripherals. Software sees three per-pin registers (output latch, direction, pull-up enable) and one retention status/acknowledge register. For every pin the block decides who owns the pad. An enabled analog function takes the pin first. An enabled digital peripheral comes next. Otherwise the port itself owns it. The block also forms the value returned by a read of the latch register and decides when the weak pull-up may be switched on.

Three low-power behaviours are modelled through a two-bit power mode input. In light stop nothing changes. Full power-down wipes every port register, so the pins come back at their reset defaults. Partial power-down freezes the pad controls and raises a retention flag. The pads stay frozen until software writes a 1 to the acknowledge bit. Pad controls and read data are registered, so each appears one clock after its cause.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous reset every pin is an input with its pull-up off and its input buffer on: pad_oe=0, pad_pull=0, pad_ibuf_en all ones. The direction, pull-enable and retention registers read 0.
- R2: A pin owned by the port has pad_oe equal to its direction bit and pad_out equal to its latch bit, one clock after the register write.
- R3: A write to the latch (address 0) while a pin is an input updates the latch without driving the pad. The stored value appears on pad_out as soon as the direction bit (address 1) becomes 1.
- R4: A read of address 0 returns the latch bit for a pin with direction 1 and the pad_in bit for a pin with direction 0.
- R5: When alt_en is set for a pin and its analog enable is clear, pad_oe and pad_out follow alt_oe and alt_out. Reads of address 0 still select their source by the direction bit.
- R6: When ana_en is set, pad_oe, pad_pull and pad_ibuf_en are all 0 for that pin even if alt_en is also set. A read of address 0 returns 0 for that pin while its direction bit is 0.
- R7: pad_pull is 1 only if the pull-enable bit (address 2) is set, the pin is not driven by the port or by a peripheral, and analog is off.
- R8: While pwr_mode=3 (full power-down) all registers are cleared. The pads take the reset defaults of R1, and the retention flag reads 0 afterwards.
- R9: Entering pwr_mode=2 (partial power-down) sets the retention flag (address 3, bit 0). pad_oe, pad_out, pad_pull and pad_ibuf_en then hold their values, even across later register writes.
- R10: Writing 1 to bit 0 of address 3 clears the retention flag, and the pads follow the registers again from the next clock.
- R11: pwr_mode=1 (light stop) changes no register, pad control or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 latch, 1 direction, 2 pull enable, 3 retention |
| reg_wdata | input | NPINS | Write data; bit 0 is the acknowledge at address 3 |
| reg_rdata | output | NPINS | Registered read data for reg_addr |
| pwr_mode | input | 2 | 0 run, 1 light stop, 2 partial power-down, 3 full power-down |
| ana_en | input | NPINS | Analog function enable per pin |
| alt_en | input | NPINS | Digital peripheral enable per pin |
| alt_oe | input | NPINS | Peripheral output enable per pin |
| alt_out | input | NPINS | Peripheral output value per pin |
| pad_in | input | NPINS | Pad input value |
| pad_oe | output | NPINS | Pad output buffer enable |
| pad_out | output | NPINS | Pad output value |
| pad_pull | output | NPINS | Pull-up enable to pad |
| pad_ibuf_en | output | NPINS | Pad input buffer enable |

## Verification
A wrong ownership priority or a stale direction bit shows on pad_oe and pad_out one clock after the enable or register change. A wrong read-source select shows on reg_rdata one clock after the address is presented. A retention flag stuck low lets register writes leak to the pads on the very next clock. A flag stuck high keeps the pads frozen after the acknowledge, and both are visible within two clocks of the write. A missed wipe in full power-down shows as leftover direction or pull-up state on the first read after exit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PWR_RUN     = 2'd0,
    PWR_LIGHT   = 2'd1,
    PWR_PARTIAL = 2'd2,
    PWR_DEEP    = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ADDR_LATCH = 2'd0,
    ADDR_DIR   = 2'd1,
    ADDR_PULL  = 2'd2,
    ADDR_RET   = 2'd3
  } reg_addr_e;

  localparam int ACK_BIT = 0;
endpackage

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic ana,
  input  logic alt,
  input  logic alt_oe,
  input  logic alt_out,
  input  logic dir,
  input  logic latch,
  input  logic pue,
  input  logic pin_in,
  output logic oe_nx,
  output logic out_nx,
  output logic pull_nx,
  output logic ibuf_nx,
  output logic rd_bit
);
  always_comb begin
    if (ana) begin
      oe_nx   = 1'b0;
      out_nx  = 1'b0;
      ibuf_nx = 1'b0;
    end else if (alt) begin
      oe_nx   = alt_oe;
      out_nx  = alt_out;
      ibuf_nx = 1'b1;
    end else begin
      oe_nx   = dir;
      out_nx  = latch;
      ibuf_nx = 1'b1;
    end
    pull_nx = pue && !oe_nx && !ana;
    // the direction bit picks the read source in every ownership case
    if (dir)       rd_bit = latch;
    else if (ana)  rd_bit = 1'b0;
    else           rd_bit = pin_in;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             retain_req,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] latch_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] pue_q,
  output logic             hold_q
);
  import gpio_port_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      latch_q <= '0;
      dir_q   <= '0;
      pue_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      if (we) begin
        case (reg_addr_e'(addr))
          ADDR_LATCH: latch_q <= wdata;
          ADDR_DIR:   dir_q   <= wdata;
          ADDR_PULL:  pue_q   <= wdata;
          ADDR_RET:   if (wdata[ACK_BIT]) hold_q <= 1'b0;
          default:    ;
        endcase
      end
      if (retain_req) hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_pad_stage.sv
module gpio_pad_stage #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             hold,
  input  logic [NPINS-1:0] oe_nx,
  input  logic [NPINS-1:0] out_nx,
  input  logic [NPINS-1:0] pull_nx,
  input  logic [NPINS-1:0] ibuf_nx,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pull,
  output logic [NPINS-1:0] pad_ibuf_en
);
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      pad_oe      <= '0;
      pad_out     <= '0;
      pad_pull    <= '0;
      pad_ibuf_en <= '1;
    end else if (!hold) begin
      pad_oe      <= oe_nx;
      pad_out     <= out_nx;
      pad_pull    <= pull_nx;
      pad_ibuf_en <= ibuf_nx;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  input  logic [1:0]       pwr_mode,
  input  logic [NPINS-1:0] ana_en,
  input  logic [NPINS-1:0] alt_en,
  input  logic [NPINS-1:0] alt_oe,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pull,
  output logic [NPINS-1:0] pad_ibuf_en
);
  import gpio_port_pkg::*;

  logic             wipe;
  logic             retain_req;
  logic [NPINS-1:0] latch_q, dir_q, pue_q;
  logic             hold_q;
  logic [NPINS-1:0] oe_nx, out_nx, pull_nx, ibuf_nx, rd_vec;

  assign wipe       = (pwr_mode_e'(pwr_mode) == PWR_DEEP);
  assign retain_req = (pwr_mode_e'(pwr_mode) == PWR_PARTIAL) && !hold_q;

  gpio_port_regs #(.NPINS(NPINS)) regs_i (
    .clk(clk), .rst(rst), .wipe(wipe), .retain_req(retain_req),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q), .hold_q(hold_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_mux mux_i (
      .ana(ana_en[p]), .alt(alt_en[p]), .alt_oe(alt_oe[p]), .alt_out(alt_out[p]),
      .dir(dir_q[p]), .latch(latch_q[p]), .pue(pue_q[p]), .pin_in(pad_in[p]),
      .oe_nx(oe_nx[p]), .out_nx(out_nx[p]), .pull_nx(pull_nx[p]),
      .ibuf_nx(ibuf_nx[p]), .rd_bit(rd_vec[p])
    );
  end

  gpio_pad_stage #(.NPINS(NPINS)) pads_i (
    .clk(clk), .rst(rst), .wipe(wipe), .hold(hold_q),
    .oe_nx(oe_nx), .out_nx(out_nx), .pull_nx(pull_nx), .ibuf_nx(ibuf_nx),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull), .pad_ibuf_en(pad_ibuf_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr_e'(reg_addr))
        ADDR_LATCH: reg_rdata <= rd_vec;
        ADDR_DIR:   reg_rdata <= dir_q;
        ADDR_PULL:  reg_rdata <= pue_q;
        default:    reg_rdata <= NPINS'(hold_q);
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPINS = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [NPINS-1:0] reg_wdata,
  input logic [1:0]       pwr_mode,
  input logic [NPINS-1:0] ana_en,
  input logic [NPINS-1:0] alt_en,
  input logic [NPINS-1:0] dir_q,
  input logic             hold_q,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_pull,
  input logic [NPINS-1:0] pad_ibuf_en
);
  assert_port_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && pwr_mode != 2'd3) |=>
      ((pad_oe & ~$past(ana_en | alt_en)) == ($past(dir_q) & ~$past(ana_en | alt_en))));

  assert_analog_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && pwr_mode != 2'd3) |=>
      (((pad_oe | pad_pull | pad_ibuf_en) & $past(ana_en)) == '0));

  assert_pull_excl_R7: assert property (@(posedge clk) disable iff (rst)
    ((pad_pull & pad_oe) == '0));

  assert_deep_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd3) |=> (pad_oe == '0 && pad_pull == '0 && !hold_q));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_q && pwr_mode != 2'd3) |=>
      ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull) && $stable(pad_ibuf_en)));

  assert_ack_release_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd3 && reg_wdata[0] && pwr_mode != 2'd2) |=> !hold_q);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pwr_mode(pwr_mode), .ana_en(ana_en), .alt_en(alt_en), .dir_q(dir_q),
  .hold_q(hold_q), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
  .pad_ibuf_en(pad_ibuf_en)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [1:0]   pwr_mode = 2'd0;
  logic [N-1:0] ana_en = '0, alt_en = '0, alt_oe = '0, alt_out = '0, pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pad_pull, pad_ibuf_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_mode(pwr_mode), .ana_en(ana_en), .alt_en(alt_en),
    .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pull(pad_pull), .pad_ibuf_en(pad_ibuf_en)
  );

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1", "pad_oe", pad_oe, '0);
    check("R1", "pad_pull", pad_pull, '0);
    check("R1", "pad_ibuf_en", pad_ibuf_en, '1);
    rd(2'd1, v); check("R1", "dir reg", v, '0);
    rd(2'd2, v); check("R1", "pull reg", v, '0);
    rd(2'd3, v); check("R1", "ret flag", v, '0);
  endtask

  task automatic t_port_drive();
    logic [N-1:0] v;
    wr(2'd0, 6'h2A); settle();
    check("R3", "no drive while input", pad_oe, '0);
    wr(2'd1, 6'h3F); settle();
    check("R2", "pad_oe follows dir", pad_oe, 6'h3F);
    check("R3", "latched value drives", pad_out, 6'h2A);
    rd(2'd0, v); check("R4", "read latch dir=1", v, 6'h2A);
    pad_in = 6'h15;
    wr(2'd1, 6'h0F); settle();
    check("R2", "pad_oe partial dir", pad_oe, 6'h0F);
    rd(2'd0, v); check("R4", "mixed read source", v, 6'h1A);
  endtask

  task automatic t_alt();
    logic [N-1:0] v;
    alt_en = 6'h03; alt_oe = 6'h01; alt_out = 6'h01; settle();
    check("R5", "peripheral oe", pad_oe, 6'h0D);
    check("R5", "peripheral out", pad_out, 6'h29);
    rd(2'd0, v); check("R5", "read still by dir", v, 6'h1A);
  endtask

  task automatic t_analog();
    logic [N-1:0] v;
    wr(2'd1, 6'h3E); wr(2'd2, 6'h3F);
    ana_en = 6'h03; settle();
    check("R6", "analog beats peripheral oe", pad_oe, 6'h3C);
    check("R6", "input buffer off", pad_ibuf_en, 6'h3C);
    check("R6", "analog pull off", pad_pull, 6'h00);
    rd(2'd0, v); check("R6", "analog input reads 0", v, 6'h2A);
    ana_en = '0; alt_en = '0; alt_oe = '0; alt_out = '0;
  endtask

  task automatic t_pull();
    wr(2'd1, 6'h30); wr(2'd2, 6'h3F);
    alt_en = 6'h03; alt_oe = 6'h01; settle();
    check("R7", "pull off where driven", pad_pull, 6'h0E);
    ana_en = 6'h04; settle();
    check("R7", "pull off under analog", pad_pull, 6'h0A);
    wr(2'd2, 6'h02); settle();
    check("R7", "pull follows enable", pad_pull, 6'h02);
    ana_en = '0; alt_en = '0; alt_oe = '0;
  endtask

  task automatic t_light();
    logic [N-1:0] v;
    wr(2'd0, 6'h33); wr(2'd1, 6'h0F); wr(2'd2, 6'h30); settle();
    @(negedge clk); pwr_mode = 2'd1;
    repeat (5) @(negedge clk);
    pwr_mode = 2'd0; settle();
    check("R11", "pad_oe kept", pad_oe, 6'h0F);
    check("R11", "pad_out kept", pad_out, 6'h33);
    check("R11", "pad_pull kept", pad_pull, 6'h30);
    rd(2'd1, v); check("R11", "dir kept", v, 6'h0F);
    rd(2'd3, v); check("R11", "no flag", v, '0);
  endtask

  task automatic t_partial();
    logic [N-1:0] v;
    wr(2'd1, 6'h3F); wr(2'd2, 6'h00); wr(2'd0, 6'h15); settle();
    @(negedge clk); pwr_mode = 2'd2;
    @(negedge clk); pwr_mode = 2'd0;
    settle();
    rd(2'd3, v); check("R9", "flag set", v, 6'h01);
    wr(2'd0, 6'h2A); wr(2'd1, 6'h0C); settle();
    check("R9", "pad_out frozen", pad_out, 6'h15);
    check("R9", "pad_oe frozen", pad_oe, 6'h3F);
    rd(2'd1, v); check("R9", "dir reg still written", v, 6'h0C);
    wr(2'd3, 6'h00); settle();
    check("R10", "ack bit 0 keeps freeze", pad_oe, 6'h3F);
    wr(2'd3, 6'h01); settle();
    rd(2'd3, v); check("R10", "flag cleared", v, '0);
    check("R10", "pad_oe released", pad_oe, 6'h0C);
    check("R10", "pad_out released", pad_out, 6'h2A);
  endtask

  task automatic t_deep();
    logic [N-1:0] v;
    wr(2'd1, 6'h3F); wr(2'd2, 6'h3F); settle();
    @(negedge clk); pwr_mode = 2'd2;
    @(negedge clk); pwr_mode = 2'd3;
    repeat (2) @(negedge clk);
    pwr_mode = 2'd0; settle();
    check("R8", "pad_oe default", pad_oe, '0);
    check("R8", "pad_pull default", pad_pull, '0);
    check("R8", "ibuf default", pad_ibuf_en, '1);
    rd(2'd1, v); check("R8", "dir wiped", v, '0);
    rd(2'd2, v); check("R8", "pull wiped", v, '0);
    rd(2'd3, v); check("R8", "flag 0 after exit", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_port_drive();
    t_alt();
    t_analog();
    t_pull();
    t_light();
    t_partial();
    t_deep();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule